// File: doc/BRIEF.md
# Parity-capable bus interface latch

A bank of level-sensitive data latches that places its contents on a shared bus through three-state drivers. One latch-enable, one active-low force-high (preset) and one active-low force-low (clear) act on every bit at once. While the latch enable is high, the stored word follows the data inputs. When it falls, the word present at that moment is kept until the enable rises again or a preset or clear overrides it. Preset has the higher priority.

Output drive is granted by a group of active-low enables that must all be low together. This lets several independent controllers (a chip select, a transfer engine, a read strobe) each veto the bus. A parameter picks a single enable or three combined ones. A second parameter selects true or complemented output polarity. The width is a parameter, so an extra parity bit or two fits beside a byte. The bus is a three-state port. A separate drive flag reports whether the drivers are on, so the high-impedance state can be observed directly.

Top module: `parity_bus_latch`

## Requirements
- R1: With preset_n_i and clear_n_i both high and le_i high, the stored word equals d_i and changes with d_i in the same cycle.
- R2: When le_i falls with preset_n_i and clear_n_i high, the value on d_i just before the fall is kept, and later changes of d_i while le_i stays low have no effect on bus_o.
- R3: With clear_n_i low and preset_n_i high, every stored bit is 0, whatever the levels of le_i and d_i.
- R4: With preset_n_i low, every stored bit is 1, whatever the levels of clear_n_i, le_i and d_i.
- R5: Releasing clear_n_i (preset_n_i high) while le_i is low leaves the stored word at all zeros until le_i next goes high.
- R6: drive_o is 1 only when every bit of oe_n_i is 0. When any bit of oe_n_i is 1, drive_o is 0 and every bit of bus_o is high-impedance.
- R7: oe_n_i affects only the drivers: loading, holding, preset and clear work while the bus is released, and the stored word appears as soon as drive is granted.
- R8: With INVERT = 1, bus_o carries the bitwise complement of the stored word, so preset shows all zeros and clear shows all ones.
- R9: With OE_COUNT = 1, the single bit oe_n_i[0] alone decides the drive.
- R10: The block works at WIDTH of 8, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| le_i | input | 1 | Latch enable, high = transparent |
| preset_n_i | input | 1 | Active-low force of all stored bits to 1, highest priority |
| clear_n_i | input | 1 | Active-low force of all stored bits to 0 |
| oe_n_i | input | OE_COUNT | Active-low drive enables, all must be low to drive |
| d_i | input | WIDTH | Data inputs |
| bus_o | output | WIDTH | Three-state bus outputs |
| drive_o | output | 1 | 1 while bus_o is actively driven |

## Verification
Every result of this block is combinational or level-sensitive, so each output is due in the same cycle as the input change that causes it. No register lies on any path. The bench changes inputs one time unit after a rising clock edge and samples all instances at the following falling edge, where its behavioural model is also advanced. A capture is modelled by never moving d_i and le_i in the same step, so the word held after a fall is the one from the previous sample.

// File: rtl/parity_bus_latch_pkg.sv
package parity_bus_latch_pkg;

  // Output value of one bit for the chosen polarity.
  function automatic logic pin_level(input logic stored, input bit invert);
    return invert ? ~stored : stored;
  endfunction

  // Next level of one storage bit for the control levels (level-sensitive).
  function automatic logic next_store(input logic cur, input logic din,
                                      input logic le, input logic set_n,
                                      input logic rst_n);
    logic nxt;
    if (!set_n)      nxt = 1'b1;
    else if (!rst_n) nxt = 1'b0;
    else if (le)     nxt = din;
    else             nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/pbl_store.sv
module pbl_store #(
  parameter int WIDTH = 8
) (
  input  logic             le_i,
  input  logic             set_n_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  import parity_bus_latch_pkg::*;

  logic force_hi;
  logic force_lo;
  logic open_win;

  assign force_hi = ~set_n_i;
  assign force_lo = set_n_i & ~rst_n_i;
  assign open_win = set_n_i & rst_n_i & le_i;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_latch begin
      if (force_hi || force_lo || open_win)
        q_o[b] = next_store(q_o[b], d_i[b], le_i, set_n_i, rst_n_i);
    end
  end

  always_comb begin
    if (force_hi) begin
      AST_PRESET_ALL_ONES: assert (q_o == {WIDTH{1'b1}}) else $error("preset not high"); // R4
    end
    if (force_lo) begin
      AST_CLEAR_ALL_ZERO: assert (q_o == '0) else $error("clear not low"); // R3
    end
    if (open_win) begin
      AST_TRANSPARENT: assert (q_o == d_i) else $error("not transparent"); // R1
    end
  end

endmodule

// File: rtl/pbl_grant.sv
module pbl_grant #(
  parameter int OE_COUNT = 3
) (
  input  logic [OE_COUNT-1:0] oe_n_i,
  output logic                grant_o
);

  if (OE_COUNT == 1) begin : g_single
    assign grant_o = ~oe_n_i[0];
  end else begin : g_multi
    assign grant_o = ~|oe_n_i;
  end

  always_comb begin
    if (oe_n_i != '0) begin
      AST_ANY_VETO_RELEASES: assert (!grant_o) else $error("drive despite veto"); // R6
    end
  end

endmodule

// File: rtl/pbl_polarity.sv
module pbl_polarity #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] pin_o
);
  import parity_bus_latch_pkg::*;

  for (genvar b = 0; b < WIDTH; b++) begin : g_pol
    assign pin_o[b] = pin_level(q_i[b], INVERT);
  end

  always_comb begin
    if (INVERT) begin
      AST_INVERTED_VIEW: assert ((pin_o ^ q_i) == {WIDTH{1'b1}}) else $error("not inverted"); // R8
    end else begin
      AST_TRUE_VIEW: assert ((pin_o ^ q_i) == '0) else $error("not true"); // R8
    end
  end

endmodule

// File: rtl/parity_bus_latch.sv
module parity_bus_latch #(
  parameter int WIDTH    = 8,
  parameter int OE_COUNT = 3,
  parameter bit INVERT   = 1'b0
) (
  input  logic                le_i,
  input  logic                preset_n_i,
  input  logic                clear_n_i,
  input  logic [OE_COUNT-1:0] oe_n_i,
  input  logic [WIDTH-1:0]    d_i,
  output wire  [WIDTH-1:0]    bus_o,
  output logic                drive_o
);

  logic [WIDTH-1:0] stored_q;
  logic [WIDTH-1:0] pin_val;
  logic             grant;

  pbl_store #(.WIDTH(WIDTH)) u_store (
    .le_i    (le_i),
    .set_n_i (preset_n_i),
    .rst_n_i (clear_n_i),
    .d_i     (d_i),
    .q_o     (stored_q)
  );

  pbl_grant #(.OE_COUNT(OE_COUNT)) u_grant (
    .oe_n_i  (oe_n_i),
    .grant_o (grant)
  );

  pbl_polarity #(.WIDTH(WIDTH), .INVERT(INVERT)) u_pol (
    .q_i   (stored_q),
    .pin_o (pin_val)
  );

  assign drive_o = grant;
  assign bus_o   = grant ? pin_val : {WIDTH{1'bz}};

  always_comb begin
    if (!preset_n_i) begin
      AST_PRESET_OVER_CLEAR: assert (pin_val == (INVERT ? '0 : {WIDTH{1'b1}})) else $error("preset lost"); // R4
    end
  end

endmodule

// File: tb/parity_bus_latch_tb.sv
module parity_bus_latch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       le = 1'b0;
  logic       pre_n = 1'b1;
  logic       clr_n = 1'b0;
  logic [2:0] oe_n = 3'b000;
  logic [9:0] d = '0;

  wire  [7:0] bus_a;
  wire  [9:0] bus_b;
  wire  [8:0] bus_c;
  logic       drv_a, drv_b, drv_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [9:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_bus_latch #(.WIDTH(8), .OE_COUNT(3), .INVERT(1'b0)) dut_i (
    .le_i(le), .preset_n_i(pre_n), .clear_n_i(clr_n), .oe_n_i(oe_n),
    .d_i(d[7:0]), .bus_o(bus_a), .drive_o(drv_a));

  parity_bus_latch #(.WIDTH(10), .OE_COUNT(3), .INVERT(1'b1)) dut_inv_i (
    .le_i(le), .preset_n_i(pre_n), .clear_n_i(clr_n), .oe_n_i(oe_n),
    .d_i(d), .bus_o(bus_b), .drive_o(drv_b));

  parity_bus_latch #(.WIDTH(9), .OE_COUNT(1), .INVERT(1'b0)) dut_one_i (
    .le_i(le), .preset_n_i(pre_n), .clear_n_i(clr_n), .oe_n_i(oe_n[0]),
    .d_i(d[8:0]), .bus_o(bus_c), .drive_o(drv_c));

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One step: drive after the rising edge, advance model and compare at the falling edge.
  task automatic step(input string tag, input logic p, input logic c, input logic l,
                      input logic [9:0] dv, input logic [2:0] o);
    bit exp_drv3;
    bit exp_drv1;
    @(posedge clk);
    #1;
    pre_n = p; clr_n = c; le = l; d = dv; oe_n = o;
    @(negedge clk);
    if (p == 1'b0)      model = 10'h3FF;
    else if (c == 1'b0) model = 10'h000;
    else if (l == 1'b1) model = dv;
    exp_drv3 = (o == 3'b000);
    exp_drv1 = (o[0] == 1'b0);
    check({tag, " true8 drive"}, {9'd0, drv_a}, {9'd0, exp_drv3});
    check({tag, " inv10(R8) drive"}, {9'd0, drv_b}, {9'd0, exp_drv3});
    check({tag, " one9(R9,R10) drive"}, {9'd0, drv_c}, {9'd0, exp_drv1});
    if (exp_drv3) begin
      check({tag, " true8 value"}, {2'b00, bus_a}, {2'b00, model[7:0]});
      check({tag, " inv10(R8) value"}, bus_b, ~model);
    end
    if (exp_drv1)
      check({tag, " one9(R9,R10) value"}, {1'b0, bus_c}, {1'b0, model[8:0]});
  endtask

  initial begin
    // Clear as the bench reset, then clear independent of le and d
    step("R3 reset clear", 1, 0, 0, 10'h000, 3'b000);
    step("R3 clear le high", 1, 0, 1, 10'h3A5, 3'b000);
    step("R3 clear data move", 1, 0, 1, 10'h15A, 3'b000);
    // Preset alone and over clear
    step("R4 preset over clear", 0, 0, 1, 10'h0F0, 3'b000);
    step("R4 preset le low", 0, 1, 0, 10'h000, 3'b000);
    step("R4 preset data move", 0, 1, 1, 10'h2C3, 3'b000);
    // Release clear with le low: stays zero
    step("R5 clear again", 1, 0, 0, 10'h155, 3'b000);
    step("R5 release le low", 1, 1, 0, 10'h155, 3'b000);
    step("R5 data moves", 1, 1, 0, 10'h2AA, 3'b000);
    check("R5 explicit zero", {2'b00, bus_a}, 10'h000);
    // Transparent
    step("R1 open", 1, 1, 1, 10'h2AA, 3'b000);
    step("R1 follow a", 1, 1, 1, 10'h0F3, 3'b000);
    step("R1 follow b", 1, 1, 1, 10'h3FF, 3'b000);
    step("R1 follow c", 1, 1, 1, 10'h1C6, 3'b000);
    // Capture on fall and hold
    step("R2 fall", 1, 1, 0, 10'h1C6, 3'b000);
    step("R2 hold a", 1, 1, 0, 10'h000, 3'b000);
    step("R2 hold b", 1, 1, 0, 10'h3FF, 3'b000);
    check("R2 explicit hold", {2'b00, bus_a}, 10'h0C6);
    // Enable vetoes, one at a time and together
    step("R6 veto bit0", 1, 1, 0, 10'h3FF, 3'b001);
    step("R6 veto bit1", 1, 1, 0, 10'h3FF, 3'b010);
    step("R6 veto bit2", 1, 1, 0, 10'h3FF, 3'b100);
    step("R6 veto all", 1, 1, 0, 10'h3FF, 3'b111);
    // Storage keeps working while released
    step("R7 load hidden", 1, 1, 1, 10'h0AB, 3'b111);
    step("R7 latch hidden", 1, 1, 0, 10'h0AB, 3'b111);
    step("R7 data move hidden", 1, 1, 0, 10'h354, 3'b110);
    step("R7 show load", 1, 1, 0, 10'h354, 3'b000);
    check("R7 explicit shown", {2'b00, bus_a}, 10'h0AB);
    step("R7 clear hidden", 1, 0, 0, 10'h354, 3'b011);
    step("R7 release hidden", 1, 1, 0, 10'h354, 3'b011);
    step("R7 show clear", 1, 1, 0, 10'h354, 3'b000);
    step("R7 preset hidden", 0, 1, 0, 10'h000, 3'b101);
    step("R7 show preset", 1, 1, 0, 10'h000, 3'b000);
    check("R8 inverted preset pins", bus_b, 10'h000);
    step("R8 clear view", 1, 0, 0, 10'h000, 3'b000);
    check("R8 inverted clear pins", bus_b, 10'h3FF);
    // Single enable instance ignores bits 1 and 2
    step("R9 single granted", 1, 1, 1, 10'h1E1, 3'b110);
    step("R10 width walk", 1, 1, 1, 10'h300, 3'b000);
    step("R10 width walk b", 1, 1, 0, 10'h300, 3'b000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule